// File: doc/BRIEF.md
# Hypercube Message Router Node

This block is one node of a binary hypercube network. It owns one outgoing and one incoming link per dimension and a set of local processor ports. Every cycle it gathers the words arriving on its links, the word at the head of a small store, and the words that local processors offer. It then decides where each one goes: onward on a link, into the store, or out to a local processor. A word carries the part of its node address that still has to be corrected. Each hop across dimension `d` inverts bit `d` of that address, so a word whose address field is all zeros has arrived.

A word goes out on a free link whose dimension still differs from its target. When no such link is free, it waits in the store. When the store has no room, a word that came in on a link is pushed out on any free link, even one that moves it further from its target. Words never stall on a link, so incoming link channels carry only a valid bit, and every node must take whatever arrives. Local injection is the one place with back-pressure. It uses valid/ready, with a transfer on any cycle where both are high. Ready may depend on this cycle's link arrivals and on the valid bits of lower-numbered injection ports, but never on the port's own valid. Delivery to processors has no ready: a processor takes the word in the cycle it is presented.

Word layout, on links and at injection alike: bits `[DIMS-1:0]` hold the node address field, the next `PIDX_W` bits hold the target processor index, and the top `DATA_W` bits hold the payload. At injection the address field is the absolute destination node. On links it is the relative address.

Top module: `hcr_node`

## Requirements
- R1: After reset no outgoing link valid and no delivery valid is asserted, and the store is empty.
- R2: An injected word enters the network with address field equal to `node_addr` XOR the destination node given at injection; processor index and payload are carried unchanged.
- R3: A word that is not delivered leaves on the lowest-numbered link not yet taken this cycle whose bit is 1 in its address field, and the copy sent on link `d` has bit `d` of the address field inverted.
- R4: A word with an all-zero address field is presented on the delivery port named by its processor index, payload only. Each port takes at most one word per cycle, and a second such word in the same cycle is treated like a word with no usable link.
- R5: Sources claim links, delivery ports and store room in a fixed order: incoming links 0 upward, then the store head, then injection ports 0 upward.
- R6: The store holds `BUF_DEPTH` words first-in first-out, and only its head can leave, at most one word per cycle. Several words may enter in one cycle, appended in the order of R5. Room is the free slot count at the start of the cycle, not counting the head leaving that cycle.
- R7: A word from an incoming link that has no usable link and finds no room in the store leaves on the lowest-numbered free link, with that link's address bit inverted.
- R8: `inj_ready[p]` is high exactly when port `p`'s word could be delivered, sent on a link that moves it closer (R3), or stored. A refused word changes nothing.
- R9: No word arriving on a link is ever lost. The words presented on the outputs, plus the change in store occupancy, equal the words accepted in the previous cycle.
- R10: Link and delivery outputs are registered, and appear on the cycle after the decision that produced them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_addr | input | DIMS | This node's address |
| lin_valid | input | DIMS | Incoming word present, one bit per dimension |
| lin_msg | input | DIMS*MSG_W | Incoming words, link d at bits [d*MSG_W +: MSG_W] |
| lout_valid | output | DIMS | Outgoing word present, one bit per dimension |
| lout_msg | output | DIMS*MSG_W | Outgoing words, address bit already inverted |
| inj_valid | input | NPROC | Local processor offers a word |
| inj_ready | output | NPROC | Node accepts the offered word this cycle |
| inj_msg | input | NPROC*MSG_W | Offered words, absolute destination in the address field |
| dlv_valid | output | NPROC | Word delivered to a local processor |
| dlv_data | output | NPROC*DATA_W | Delivered payloads |

## Verification
The bench first crowds one dimension so that injected words pile into the store. If the room rule or the in-order append were wrong, words would be lost or would leave out of order, and an overfull store would overwrite its oldest entry. It then holds the store full while several links bring words that want the same busy dimension. A design that stalled or dropped them instead of deflecting would show a missing output, and one that picked a link other than the lowest free one would show the word on the wrong link. Two all-zero words for one processor in the same cycle check that the second waits rather than overwriting the first. Long random traffic then compares every output and every ready bit against a queue-based model on each clock.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  // decision taken for one source in one cycle
  typedef enum logic [1:0] {
    ACT_IDLE    = 2'd0,
    ACT_SEND    = 2'd1,
    ACT_DELIVER = 2'd2,
    ACT_STORE   = 2'd3
  } act_e;

  // class of a source in the allocation order
  typedef enum logic [1:0] {
    SRC_LINK  = 2'd0,
    SRC_HEAD  = 2'd1,
    SRC_LOCAL = 2'd2
  } src_e;
endpackage

// File: rtl/hcr_inj_xlate.sv
// Turns the absolute destination of each injected word into a relative one.
module hcr_inj_xlate #(
  parameter int DIMS  = 12,
  parameter int NPROC = 16,
  parameter int MSG_W = 48
) (
  input  logic [DIMS-1:0]        node_addr,
  input  logic [NPROC*MSG_W-1:0] inj_msg,
  output logic [NPROC*MSG_W-1:0] inj_rel
);
  localparam int UPPER_W = MSG_W - DIMS;

  for (genvar p = 0; p < NPROC; p++) begin : g_port
    assign inj_rel[p*MSG_W +: MSG_W] =
      {inj_msg[p*MSG_W + DIMS +: UPPER_W], inj_msg[p*MSG_W +: DIMS] ^ node_addr};
  end
endmodule

// File: rtl/hcr_fifo.sv
// Shift-style store: several pushes per cycle, head-only pop.
module hcr_fifo #(
  parameter int WIDTH = 48,
  parameter int DEPTH = 4,
  parameter int NPUSH = 28,
  parameter int CNT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPUSH-1:0]       push_valid,
  input  logic [NPUSH*WIDTH-1:0] push_data,
  input  logic                   pop,
  output logic                   head_valid,
  output logic [WIDTH-1:0]       head,
  output logic [CNT_W-1:0]       count
);
  logic [WIDTH-1:0] mem     [DEPTH];
  logic [WIDTH-1:0] mem_nxt [DEPTH];
  logic [CNT_W-1:0] count_nxt;

  assign head_valid = (count != '0);
  assign head       = mem[0];

  always_comb begin
    int fill;
    for (int i = 0; i < DEPTH; i++) mem_nxt[i] = mem[i];
    fill = int'(count);
    if (pop && head_valid) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_nxt[i] = mem[i+1];
      fill = fill - 1;
    end
    for (int k = 0; k < NPUSH; k++) begin
      if (push_valid[k]) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (i == fill) mem_nxt[i] = push_data[k*WIDTH +: WIDTH];
        end
        fill = fill + 1;
      end
    end
    count_nxt = CNT_W'(fill);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) mem[i] <= mem_nxt[i];
  end
endmodule

// File: rtl/hcr_alloc.sv
// Single-cycle allocator: walks all sources in priority order and
// hands out links, delivery ports and store room.
module hcr_alloc
  import hcr_pkg::*;
#(
  parameter int DIMS      = 12,
  parameter int NPROC     = 16,
  parameter int PIDX_W    = 4,
  parameter int DATA_W    = 32,
  parameter int MSG_W     = 48,
  parameter int BUF_DEPTH = 4,
  parameter int CNT_W     = 3
) (
  input  logic [DIMS-1:0]              lin_valid,
  input  logic [DIMS*MSG_W-1:0]        lin_msg,
  input  logic                         head_valid,
  input  logic [MSG_W-1:0]             head_msg,
  input  logic [CNT_W-1:0]             buf_count,
  input  logic [NPROC-1:0]             inj_valid,
  input  logic [NPROC*MSG_W-1:0]       inj_msg,
  output logic [NPROC-1:0]             inj_ready,
  output logic [DIMS-1:0]              send_valid,
  output logic [DIMS*MSG_W-1:0]        send_msg,
  output logic [NPROC-1:0]             dlv_valid,
  output logic [NPROC*DATA_W-1:0]      dlv_data,
  output logic [DIMS+NPROC-1:0]        push_valid,
  output logic [(DIMS+NPROC)*MSG_W-1:0] push_msg,
  output logic                         pop
);
  localparam int NSRC = DIMS + 1 + NPROC;

  function automatic int lowest_set(input logic [DIMS-1:0] v);
    int r;
    r = 0;
    for (int i = DIMS - 1; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  always_comb begin
    logic [DIMS-1:0]   link_busy;
    logic [NPROC-1:0]  port_busy;
    logic [MSG_W-1:0]  msg;
    logic [DIMS-1:0]   rel;
    logic [DIMS-1:0]   fwd;
    logic [PIDX_W-1:0] pid;
    logic              vld;
    src_e              kind;
    act_e              act;
    int                room;
    int                pick;
    int                slot;

    link_busy  = '0;
    port_busy  = '0;
    send_valid = '0;
    send_msg   = '0;
    dlv_valid  = '0;
    dlv_data   = '0;
    push_valid = '0;
    push_msg   = '0;
    inj_ready  = '0;
    pop        = 1'b0;
    room       = BUF_DEPTH - int'(buf_count);

    for (int s = 0; s < NSRC; s++) begin
      if (s < DIMS) begin
        kind = SRC_LINK;
        vld  = lin_valid[s];
        msg  = lin_msg[s*MSG_W +: MSG_W];
        slot = s;
      end else if (s == DIMS) begin
        kind = SRC_HEAD;
        vld  = head_valid;
        msg  = head_msg;
        slot = 0;
      end else begin
        kind = SRC_LOCAL;
        vld  = inj_valid[s-DIMS-1];
        msg  = inj_msg[(s-DIMS-1)*MSG_W +: MSG_W];
        slot = s - 1;
      end
      rel  = msg[DIMS-1:0];
      pid  = msg[DIMS +: PIDX_W];
      fwd  = rel & ~link_busy;
      act  = ACT_IDLE;
      pick = 0;

      if (rel == '0 && !port_busy[pid]) begin
        act = ACT_DELIVER;
      end else if (fwd != '0) begin
        act  = ACT_SEND;
        pick = lowest_set(fwd);
      end else if (kind != SRC_HEAD && room > 0) begin
        act = ACT_STORE;
      end else if (kind == SRC_LINK && link_busy != '1) begin
        act  = ACT_SEND;
        pick = lowest_set(~link_busy);
      end

      if (kind == SRC_LOCAL) inj_ready[s-DIMS-1] = (act != ACT_IDLE);
      if (kind == SRC_HEAD)  pop = vld && (act != ACT_IDLE);

      if (vld) begin
        case (act)
          ACT_SEND: begin
            link_busy[pick]  = 1'b1;
            send_valid[pick] = 1'b1;
            send_msg[pick*MSG_W +: MSG_W] = msg ^ (MSG_W'(1) << pick);
          end
          ACT_DELIVER: begin
            port_busy[pid] = 1'b1;
            dlv_valid[pid] = 1'b1;
            dlv_data[int'(pid)*DATA_W +: DATA_W] = msg[MSG_W-1 -: DATA_W];
          end
          ACT_STORE: begin
            room = room - 1;
            push_valid[slot] = 1'b1;
            push_msg[slot*MSG_W +: MSG_W] = msg;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hcr_node.sv
module hcr_node #(
  parameter int DIMS      = 12,
  parameter int NPROC     = 16,
  parameter int DATA_W    = 32,
  parameter int BUF_DEPTH = 4,
  localparam int PIDX_W   = $clog2(NPROC),
  localparam int MSG_W    = DIMS + PIDX_W + DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DIMS-1:0]         node_addr,
  input  logic [DIMS-1:0]         lin_valid,
  input  logic [DIMS*MSG_W-1:0]   lin_msg,
  output logic [DIMS-1:0]         lout_valid,
  output logic [DIMS*MSG_W-1:0]   lout_msg,
  input  logic [NPROC-1:0]        inj_valid,
  output logic [NPROC-1:0]        inj_ready,
  input  logic [NPROC*MSG_W-1:0]  inj_msg,
  output logic [NPROC-1:0]        dlv_valid,
  output logic [NPROC*DATA_W-1:0] dlv_data
);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);
  localparam int NPUSH = DIMS + NPROC;

  logic [NPROC*MSG_W-1:0] inj_rel;
  logic                   head_valid;
  logic [MSG_W-1:0]       head_msg;
  logic [CNT_W-1:0]       buf_count;
  logic [NPUSH-1:0]       push_valid;
  logic [NPUSH*MSG_W-1:0] push_msg;
  logic                   pop;
  logic [DIMS-1:0]        send_valid;
  logic [DIMS*MSG_W-1:0]  send_msg;
  logic [NPROC-1:0]       to_dlv_valid;
  logic [NPROC*DATA_W-1:0] to_dlv_data;

  hcr_inj_xlate #(.DIMS(DIMS), .NPROC(NPROC), .MSG_W(MSG_W)) u_xlate (
    .node_addr (node_addr),
    .inj_msg   (inj_msg),
    .inj_rel   (inj_rel)
  );

  hcr_alloc #(
    .DIMS(DIMS), .NPROC(NPROC), .PIDX_W(PIDX_W), .DATA_W(DATA_W),
    .MSG_W(MSG_W), .BUF_DEPTH(BUF_DEPTH), .CNT_W(CNT_W)
  ) u_alloc (
    .lin_valid  (lin_valid),
    .lin_msg    (lin_msg),
    .head_valid (head_valid),
    .head_msg   (head_msg),
    .buf_count  (buf_count),
    .inj_valid  (inj_valid),
    .inj_msg    (inj_rel),
    .inj_ready  (inj_ready),
    .send_valid (send_valid),
    .send_msg   (send_msg),
    .dlv_valid  (to_dlv_valid),
    .dlv_data   (to_dlv_data),
    .push_valid (push_valid),
    .push_msg   (push_msg),
    .pop        (pop)
  );

  hcr_fifo #(.WIDTH(MSG_W), .DEPTH(BUF_DEPTH), .NPUSH(NPUSH), .CNT_W(CNT_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_data  (push_msg),
    .pop        (pop),
    .head_valid (head_valid),
    .head       (head_msg),
    .count      (buf_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lout_valid <= '0;
      dlv_valid  <= '0;
    end else begin
      lout_valid <= send_valid;
      dlv_valid  <= to_dlv_valid;
    end
  end

  always_ff @(posedge clk) begin
    lout_msg <= send_msg;
    dlv_data <= to_dlv_data;
  end
endmodule

// File: rtl/hcr_node_chk.sv
module hcr_node_chk #(
  parameter int DIMS      = 12,
  parameter int NPROC     = 16,
  parameter int BUF_DEPTH = 4,
  parameter int CNT_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIMS-1:0]  lin_valid,
  input logic [DIMS-1:0]  lout_valid,
  input logic [NPROC-1:0] inj_valid,
  input logic [NPROC-1:0] inj_ready,
  input logic [NPROC-1:0] dlv_valid,
  input logic [CNT_W-1:0] buf_count
);
  logic past_ok;
  int   taken_now;
  int   shown_now;

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_comb begin
    taken_now = $countones(lin_valid) + $countones(inj_valid & inj_ready);
    shown_now = $countones(lout_valid) + $countones(dlv_valid);
  end

  // R1: outputs quiet on the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lout_valid == '0 && dlv_valid == '0));

  // R6: store never holds more than its depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(buf_count) <= BUF_DEPTH);

  // R6: at most one word leaves the store per cycle
  a_r6_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> int'(buf_count) >= int'($past(buf_count)) - 1);

  // R9: every accepted word reappears on an output or in the store
  a_r9_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> shown_now + int'(buf_count) ==
                int'($past(buf_count)) + $past(taken_now));
endmodule

bind hcr_node hcr_node_chk #(
  .DIMS(DIMS), .NPROC(NPROC), .BUF_DEPTH(BUF_DEPTH), .CNT_W($clog2(BUF_DEPTH + 1))
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lin_valid  (lin_valid),
  .lout_valid (lout_valid),
  .inj_valid  (inj_valid),
  .inj_ready  (inj_ready),
  .dlv_valid  (dlv_valid),
  .buf_count  (buf_count)
);

// File: tb/sim_hcr_node.sv
module sim_hcr_node;
  localparam int D     = 4;
  localparam int P     = 4;
  localparam int PI    = 2;
  localparam int DW    = 16;
  localparam int MW    = D + PI + DW;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n = 1'b0;
  logic [D-1:0]      node_addr = 4'b0101;
  logic [D-1:0]      lin_valid = '0;
  logic [D*MW-1:0]   lin_msg   = '0;
  logic [D-1:0]      lout_valid;
  logic [D*MW-1:0]   lout_msg;
  logic [P-1:0]      inj_valid = '0;
  logic [P-1:0]      inj_ready;
  logic [P*MW-1:0]   inj_msg   = '0;
  logic [P-1:0]      dlv_valid;
  logic [P*DW-1:0]   dlv_data;

  hcr_node #(.DIMS(D), .NPROC(P), .DATA_W(DW), .BUF_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .node_addr(node_addr),
    .lin_valid(lin_valid), .lin_msg(lin_msg),
    .lout_valid(lout_valid), .lout_msg(lout_msg),
    .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_msg(inj_msg),
    .dlv_valid(dlv_valid), .dlv_data(dlv_data)
  );

  int    vectors = 0;
  int    errors  = 0;
  string tag     = "R1 reset";

  // reference model state
  logic [MW-1:0] q[$];
  logic [MW-1:0] pend[$];
  logic [D-1:0]  m_used;
  logic [P-1:0]  m_dused;
  int            m_size;
  logic [D-1:0]    n_lv;
  logic [D*MW-1:0] n_lm;
  logic [P-1:0]    n_dv;
  logic [P*DW-1:0] n_dd;
  logic [P-1:0]    e_ready;

  task automatic chk(input string what, input logic [511:0] act, input logic [511:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int low_free(input logic [D-1:0] cand);
    for (int i = 0; i < D; i++) if (cand[i]) return i;
    return -1;
  endfunction

  // kind 0 = from link, 1 = store head, 2 = local injection
  task automatic place(input logic [MW-1:0] m, input int kind, input bit commit, output bit ok);
    logic [D-1:0] rel;
    int pid, j;
    rel = m[D-1:0];
    pid = int'(m[D +: PI]);
    ok  = 1'b0;
    if (rel == '0 && !m_dused[pid]) begin
      ok = 1'b1;
      if (commit) begin
        m_dused[pid] = 1'b1;
        n_dv[pid] = 1'b1;
        n_dd[pid*DW +: DW] = m[MW-1 -: DW];
      end
      return;
    end
    j = low_free(rel & ~m_used);
    if (j < 0 && kind != 1 && m_size + pend.size() < DEPTH) begin
      ok = 1'b1;
      if (commit) pend.push_back(m);
      return;
    end
    if (j < 0 && kind == 0) j = low_free(~m_used);
    if (j >= 0) begin
      ok = 1'b1;
      if (commit) begin
        m_used[j] = 1'b1;
        n_lv[j] = 1'b1;
        n_lm[j*MW +: MW] = m ^ (MW'(1) << j);
      end
    end
  endtask

  task automatic model_step();
    bit ok, popped;
    logic [MW-1:0] m;
    m_used = '0; m_dused = '0; pend.delete();
    n_lv = '0; n_lm = '0; n_dv = '0; n_dd = '0;
    m_size = q.size();
    popped = 1'b0;
    for (int d = 0; d < D; d++)
      if (lin_valid[d]) place(lin_msg[d*MW +: MW], 0, 1'b1, ok);
    if (m_size > 0) begin
      place(q[0], 1, 1'b1, ok);
      popped = ok;
    end
    for (int p = 0; p < P; p++) begin
      m = inj_msg[p*MW +: MW];
      m[D-1:0] = m[D-1:0] ^ node_addr;
      place(m, 2, inj_valid[p], ok);
      e_ready[p] = ok;
    end
    if (popped) void'(q.pop_front());
    foreach (pend[i]) q.push_back(pend[i]);
  endtask

  // one clock: check ready before the edge, outputs after it
  task automatic tick();
    #1;
    model_step();
    chk("inj_ready R8", 512'(inj_ready), 512'(e_ready));
    @(posedge clk);
    @(negedge clk);
    chk("lout_valid R3 R5 R7 R10", 512'(lout_valid), 512'(n_lv));
    for (int d = 0; d < D; d++)
      if (n_lv[d]) chk("lout_msg R2 R3 R7", 512'(lout_msg[d*MW +: MW]), 512'(n_lm[d*MW +: MW]));
    chk("dlv_valid R4", 512'(dlv_valid), 512'(n_dv));
    for (int p = 0; p < P; p++)
      if (n_dv[p]) chk("dlv_data R4", 512'(dlv_data[p*DW +: DW]), 512'(n_dd[p*DW +: DW]));
  endtask

  function automatic logic [MW-1:0] mk(input logic [D-1:0] a, input int pid, input logic [DW-1:0] pay);
    return {pay, PI'(pid), a};
  endfunction

  task automatic clear_in();
    lin_valid = '0; lin_msg = '0; inj_valid = '0; inj_msg = '0;
  endtask

  task automatic set_lin(input int d, input logic [MW-1:0] m);
    lin_valid[d] = 1'b1; lin_msg[d*MW +: MW] = m;
  endtask

  task automatic set_inj(input int p, input logic [MW-1:0] m);
    inj_valid[p] = 1'b1; inj_msg[p*MW +: MW] = m;
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin clear_in(); tick(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no end expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R1: reset
    repeat (3) @(negedge clk);
    chk("lout_valid in reset R1", 512'(lout_valid), 512'(0));
    chk("dlv_valid in reset R1", 512'(dlv_valid), 512'(0));
    rst_n = 1'b1;
    q.delete();
    tick();
    chk("lout_valid after reset R1", 512'(lout_valid), 512'(0));

    // R2 R3: injection, relative address, lowest set bit used
    tag = "R2 R3 inject";
    set_inj(0, mk(4'b0100, 1, 16'h1111));   // rel 0001 -> link 0
    set_inj(1, mk(4'b0011, 2, 16'h2222));   // rel 0110 -> link 1
    tick();
    drain(2);

    // R4: two arrived words for one processor in one cycle
    tag = "R4 delivery clash";
    set_lin(0, mk(4'b0000, 2, 16'hAAAA));
    set_lin(1, mk(4'b0000, 2, 16'hBBBB));
    set_lin(2, mk(4'b0000, 3, 16'hCCCC));
    tick();
    drain(3);

    // R5: link arrival beats injection for the same link
    tag = "R5 priority";
    set_lin(2, mk(4'b0001, 0, 16'h5555));
    set_inj(0, mk(4'b0100, 1, 16'h6666));
    set_inj(3, mk(4'b0100, 1, 16'h7777));
    tick();
    drain(4);

    // R6 R8: crowd dimension 0 until the store is full, ready drops
    tag = "R6 R8 store fill";
    for (int c = 0; c < 5; c++) begin
      clear_in();
      set_lin(0, mk(4'b0001, 0, 16'(16'h0100 + c)));
      for (int p = 0; p < P; p++) set_inj(p, mk(4'b0100, p, 16'(16'h0200 + c*4 + p)));
      tick();
    end

    // R7: store full, several links want the busy dimension
    tag = "R7 deflect";
    for (int c = 0; c < 3; c++) begin
      clear_in();
      for (int d = 0; d < D; d++) set_lin(d, mk(4'b0001, d, 16'(16'h0300 + c*4 + d)));
      tick();
    end
    tag = "R6 R9 store drain";
    drain(8);

    // R9: random traffic against the model
    tag = "R9 random";
    for (int c = 0; c < 3000; c++) begin
      clear_in();
      for (int d = 0; d < D; d++)
        if ($urandom_range(0, 2) == 0) set_lin(d, MW'({$urandom, $urandom}));
      for (int p = 0; p < P; p++)
        if ($urandom_range(0, 1) == 0) set_inj(p, MW'({$urandom, $urandom}));
      if (c % 500 == 250) node_addr = D'($urandom);
      tick();
    end
    drain(10);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule